// File: doc/BRIEF.md
# Configuration Byte Readback Window Controller

This block lets software read the device's nonvolatile configuration bytes (one lock byte and three fuse bytes: low, high and extended) through the ordinary program-memory load path. Software first writes a self-program control register with two bits set: an enable bit and a readback-select bit. That write opens a short window, counted in clock cycles. A program-memory load strobe that arrives inside the window gets a configuration byte in place of the flash byte. The 16-bit load pointer picks which byte is returned.

The window closes by itself. It closes when a load is served, when a store strobe arrives, or when its cycle budget runs out. If software writes the enable bit alone, the block arms a self-program window for flash programming instead. That window has a longer budget and ends on a store strobe. While the EEPROM engine reports a write in progress, every write to the control register is dropped. The flash array, the EEPROM engine and instruction decoding lie outside the block. They appear here only as strobes and data inputs.

Top module: `cfg_readback_ctrl`

## Requirements
- R1: Readback arms only when one accepted control write has bit 3 (readback select) and bit 0 (enable) both set. A write with only bit 3 set arms nothing. An accepted write that does not set both bits closes any open readback window.
- R2: A load strobe sampled on the 1st, 2nd or 3rd rising edge after the arming edge returns a configuration byte.
- R3: Pointer 0x0000 returns the fuse low byte, 0x0001 the lock byte, 0x0002 the extended fuse byte and 0x0003 the fuse high byte.
- R4: The readback window closes on the same edge that serves a configuration read.
- R5: With no load strobe, the readback window closes on the 3rd edge after arming. A load on the 4th edge returns flash data.
- R6: A write with only bit 0 set raises `spe_bit` without opening a readback window. `spe_bit` falls on a store strobe, or on the 4th edge after the write if no store strobe arrives. A store strobe also closes an open readback window.
- R7: While no readback window is open, a load returns `flash_data` unchanged and `rd_cfg` is low.
- R8: While `ee_busy` is high, control writes are ignored. Neither a readback window nor `spe_bit` can be armed.
- R9: A programmed configuration bit (1 on the `prog_*` inputs) reads as 0, and an unprogrammed bit reads as 1.
- R10: In the lock byte only bits 1:0 carry stored bits. Bits 7:2 read as 1.
- R11: During an open window, a pointer above 0x0003 returns 0xFF and still closes the window.
- R12: `rd_data` and `rd_valid` are registered. `rd_valid` is a one-cycle pulse on the edge that samples the load strobe.
- R13: A new arming write while a window is open restarts the count. Reset clears all arming state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 0 enable, bit 3 readback select) |
| ee_busy | input | 1 | EEPROM write in progress |
| ld_strobe | input | 1 | Program-memory load strobe |
| ld_ptr | input | 16 | Load pointer |
| flash_data | input | 8 | Flash byte for the current load |
| st_strobe | input | 1 | Program-store strobe |
| prog_lo | input | 8 | Fuse low byte, 1 = programmed |
| prog_hi | input | 8 | Fuse high byte, 1 = programmed |
| prog_ext | input | 8 | Extended fuse byte, 1 = programmed |
| prog_lock | input | 2 | Lock bits, 1 = programmed |
| rd_data | output | 8 | Registered load result |
| rd_valid | output | 1 | One-cycle result valid pulse |
| rd_cfg | output | 1 | Result came from configuration store |
| win_open | output | 1 | Readback window open |
| spe_bit | output | 1 | Enable bit of the control register |

## Verification
The bench builds the block with its default window budgets: three edges for a load and four for a store. With those values, every boundary of both windows is reachable in a few cycles. That covers the last served edge, the first expired edge and the restart on re-arm. The bench can probe each one directly. The configuration inputs are chosen as asymmetric bit patterns, so that inverted polarity, swapped pointer decoding and the lock-byte padding each produce a distinct value.

// File: rtl/cfg_rb_pkg.sv
package cfg_rb_pkg;

  typedef enum logic [1:0] {
    SEL_FUSE_LO  = 2'd0,
    SEL_LOCK     = 2'd1,
    SEL_FUSE_EXT = 2'd2,
    SEL_FUSE_HI  = 2'd3
  } cfg_sel_e;

  // Last age value a window may reach before it closes.
  function automatic int unsigned win_limit(input logic rb_mode,
                                            input int unsigned ld_win,
                                            input int unsigned st_win);
    return rb_mode ? (ld_win - 1) : (st_win - 1);
  endfunction

  // Stored bits are "programmed" flags; readback inverts them.
  function automatic logic [7:0] cfg_byte(input logic [15:0] ptr,
                                          input logic [7:0]  lo,
                                          input logic [7:0]  hi,
                                          input logic [7:0]  ext,
                                          input logic [1:0]  lock);
    logic [7:0] r;
    if (ptr[15:2] != '0) begin
      r = 8'hFF;
    end else begin
      unique case (cfg_sel_e'(ptr[1:0]))
        SEL_FUSE_LO:  r = ~lo;
        SEL_LOCK:     r = {6'h3F, ~lock};
        SEL_FUSE_EXT: r = ~ext;
        default:      r = ~hi;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/cfg_rb_window.sv
module cfg_rb_window
  import cfg_rb_pkg::*;
#(
  parameter int unsigned LD_WIN = 3,
  parameter int unsigned ST_WIN = 4,
  parameter int unsigned EN_BIT = 0,
  parameter int unsigned RB_BIT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       ee_busy,
  input  logic       ld_strobe,
  input  logic       st_strobe,
  output logic       rb_open,
  output logic       en_bit,
  output logic       ld_hit
);

  localparam int unsigned WMAX = (LD_WIN > ST_WIN) ? LD_WIN : ST_WIN;
  localparam int unsigned AW   = $clog2(WMAX) + 1;

  logic          en_q, rb_q;
  logic [AW-1:0] age_q;
  logic          ctl_accept, expire, consume;
  logic [AW-1:0] limit;

  assign ctl_accept = ctl_wr && !ee_busy;
  assign rb_open    = en_q && rb_q;
  assign en_bit     = en_q;
  assign ld_hit     = rb_open && ld_strobe;
  assign limit      = AW'(win_limit(rb_q, LD_WIN, ST_WIN));
  assign expire     = en_q && (age_q == limit);
  assign consume    = ld_hit || (en_q && st_strobe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rb_q  <= 1'b0;
      age_q <= '0;
    end else if (ctl_accept) begin
      en_q  <= ctl_wdata[EN_BIT];
      rb_q  <= ctl_wdata[EN_BIT] && ctl_wdata[RB_BIT];
      age_q <= '0;
    end else if (consume || expire) begin
      en_q  <= 1'b0;
      rb_q  <= 1'b0;
      age_q <= '0;
    end else if (en_q) begin
      age_q <= age_q + 1'b1;
    end
  end

  AST_AGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rb_open |-> (age_q < AW'(LD_WIN)));  // R5

  AST_HIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hit && !ctl_wr) |=> !rb_open);  // R4

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_busy && !en_q) |=> !en_q);  // R8

  AST_STORE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && st_strobe && !ctl_wr) |=> !en_q);  // R6

endmodule

// File: rtl/cfg_rb_mux.sv
module cfg_rb_mux
  import cfg_rb_pkg::*;
#(
  parameter int unsigned PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_strobe,
  input  logic             ld_hit,
  input  logic [PTR_W-1:0] ld_ptr,
  input  logic [7:0]       flash_data,
  input  logic [7:0]       prog_lo,
  input  logic [7:0]       prog_hi,
  input  logic [7:0]       prog_ext,
  input  logic [1:0]       prog_lock,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             rd_cfg
);

  logic [7:0] cfg_val;
  logic       lock_sel_q;

  assign cfg_val = cfg_byte(16'(ld_ptr), prog_lo, prog_hi, prog_ext, prog_lock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      rd_cfg     <= 1'b0;
      lock_sel_q <= 1'b0;
    end else begin
      rd_valid <= ld_strobe;
      if (ld_strobe) begin
        rd_data    <= ld_hit ? cfg_val : flash_data;
        rd_cfg     <= ld_hit;
        lock_sel_q <= ld_hit && (ld_ptr == PTR_W'(1));
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_strobe |=> rd_valid);  // R12

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_strobe |=> !rd_valid);  // R12

  AST_LOCK_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && lock_sel_q) |-> (rd_data[7:2] == 6'h3F));  // R10

  AST_FLASH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_strobe && !ld_hit) |=> (rd_data == $past(flash_data)));  // R7

endmodule

// File: rtl/cfg_readback_ctrl.sv
module cfg_readback_ctrl #(
  parameter int unsigned LD_WIN = 3,
  parameter int unsigned ST_WIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [7:0]  ctl_wdata,
  input  logic        ee_busy,
  input  logic        ld_strobe,
  input  logic [15:0] ld_ptr,
  input  logic [7:0]  flash_data,
  input  logic        st_strobe,
  input  logic [7:0]  prog_lo,
  input  logic [7:0]  prog_hi,
  input  logic [7:0]  prog_ext,
  input  logic [1:0]  prog_lock,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        rd_cfg,
  output logic        win_open,
  output logic        spe_bit
);

  logic ld_hit;

  cfg_rb_window #(
    .LD_WIN(LD_WIN), .ST_WIN(ST_WIN), .EN_BIT(0), .RB_BIT(3)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ee_busy(ee_busy), .ld_strobe(ld_strobe), .st_strobe(st_strobe),
    .rb_open(win_open), .en_bit(spe_bit), .ld_hit(ld_hit)
  );

  cfg_rb_mux #(.PTR_W(16)) u_mux (
    .clk(clk), .rst_n(rst_n), .ld_strobe(ld_strobe), .ld_hit(ld_hit),
    .ld_ptr(ld_ptr), .flash_data(flash_data), .prog_lo(prog_lo),
    .prog_hi(prog_hi), .prog_ext(prog_ext), .prog_lock(prog_lock),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_cfg(rd_cfg)
  );

  AST_NO_SPURIOUS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_strobe && !win_open) |=> !rd_cfg);  // R7

endmodule

// File: tb/sim_cfg_readback_ctrl.sv
module sim_cfg_readback_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        ee_busy = 1'b0;
  logic        ld_strobe = 1'b0;
  logic [15:0] ld_ptr = '0;
  logic [7:0]  flash_data = 8'h3C;
  logic        st_strobe = 1'b0;
  logic [7:0]  prog_lo = 8'h62;
  logic [7:0]  prog_hi = 8'h27;
  logic [7:0]  prog_ext = 8'h05;
  logic [1:0]  prog_lock = 2'b10;
  logic [7:0]  rd_data;
  logic        rd_valid, rd_cfg, win_open, spe_bit;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [7:0] ARM  = 8'h09;
  localparam logic [7:0] FLSH = 8'h3C;

  // {idle edges after arming, pointer, expected byte, expect config}
  localparam logic [32:0] VEC [10] = '{
    {8'd0, 16'h0000, 8'h9D, 1'b1},   // R3 R9 fuse low
    {8'd1, 16'h0001, 8'hFD, 1'b1},   // R3 R10 lock
    {8'd2, 16'h0002, 8'hFA, 1'b1},   // R2 R3 extended, last edge
    {8'd0, 16'h0003, 8'hD8, 1'b1},   // R3 fuse high
    {8'd2, 16'h0003, 8'hD8, 1'b1},   // R2
    {8'd3, 16'h0000, 8'h3C, 1'b0},   // R5 expired
    {8'd5, 16'h0001, 8'h3C, 1'b0},   // R5 R7
    {8'd1, 16'h0004, 8'hFF, 1'b1},   // R11
    {8'd0, 16'h8001, 8'hFF, 1'b1},   // R11
    {8'd2, 16'hFFFF, 8'hFF, 1'b1}    // R11
  };

  always #5 clk = ~clk;

  cfg_readback_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ee_busy(ee_busy), .ld_strobe(ld_strobe), .ld_ptr(ld_ptr),
    .flash_data(flash_data), .st_strobe(st_strobe), .prog_lo(prog_lo),
    .prog_hi(prog_hi), .prog_ext(prog_ext), .prog_lock(prog_lock),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_cfg(rd_cfg),
    .win_open(win_open), .spe_bit(spe_bit)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(posedge clk); @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic load(input logic [15:0] p);
    ld_strobe = 1'b1; ld_ptr = p;
    @(posedge clk); @(negedge clk);
    ld_strobe = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R13 reset win_open", 16'(win_open), 16'd0);
    check("R13 reset spe_bit", 16'(spe_bit), 16'd0);
    check("R12 reset rd_valid", 16'(rd_valid), 16'd0);
    rst_n = 1'b1;
    idle(1);

    // table walk
    for (int v = 0; v < 10; v++) begin
      wr_ctl(ARM);
      idle(int'(VEC[v][32:25]));
      load(VEC[v][24:9]);
      check($sformatf("R2/R3 vec%0d rd_data", v), 16'(rd_data), 16'(VEC[v][8:1]));
      check($sformatf("R12 vec%0d rd_valid", v), 16'(rd_valid), 16'd1);
      check($sformatf("R7 vec%0d rd_cfg", v), 16'(rd_cfg), 16'(VEC[v][0]));
      check($sformatf("R4 vec%0d closed", v), 16'(win_open), 16'd0);
      idle(1);
      check($sformatf("R12 vec%0d pulse", v), 16'(rd_valid), 16'd0);
      idle(5);
    end

    // R4: second load after a served one returns flash
    wr_ctl(ARM);
    load(16'h0000);
    load(16'h0000);
    check("R4 second load flash", 16'(rd_data), 16'(FLSH));

    // R5: window boundary without loads
    wr_ctl(ARM);
    idle(2);
    check("R5 open after 2 edges", 16'(win_open), 16'd1);
    idle(1);
    check("R5 closed after 3 edges", 16'(win_open), 16'd0);

    // R1: readback bit alone arms nothing
    wr_ctl(8'h08);
    check("R1 bit3 alone", 16'(win_open), 16'd0);
    load(16'h0000);
    check("R1 bit3 alone load", 16'(rd_data), 16'(FLSH));
    // R1: a write without both bits closes an open window
    wr_ctl(ARM);
    wr_ctl(8'h00);
    check("R1 overwrite closes", 16'(win_open), 16'd0);

    // R8: busy EEPROM blocks arming
    ee_busy = 1'b1;
    wr_ctl(ARM);
    check("R8 busy no window", 16'(win_open), 16'd0);
    check("R8 busy no spe", 16'(spe_bit), 16'd0);
    load(16'h0001);
    check("R8 busy load flash", 16'(rd_data), 16'(FLSH));
    wr_ctl(8'h01);
    check("R8 busy no program arm", 16'(spe_bit), 16'd0);
    ee_busy = 1'b0;

    // R6: program-only window
    wr_ctl(8'h01);
    check("R6 spe set", 16'(spe_bit), 16'd1);
    check("R6 no readback", 16'(win_open), 16'd0);
    load(16'h0000);
    check("R6 load flash", 16'(rd_data), 16'(FLSH));
    idle(2);
    check("R6 spe held 3 edges", 16'(spe_bit), 16'd1);
    idle(1);
    check("R6 spe cleared 4 edges", 16'(spe_bit), 16'd0);
    wr_ctl(8'h01);
    st_strobe = 1'b1; idle(1); st_strobe = 1'b0;
    check("R6 store clears spe", 16'(spe_bit), 16'd0);
    wr_ctl(ARM);
    st_strobe = 1'b1; idle(1); st_strobe = 1'b0;
    check("R6 store closes readback", 16'(win_open), 16'd0);

    // R13: re-arm restarts the count
    wr_ctl(ARM);
    idle(2);
    wr_ctl(ARM);
    idle(2);
    load(16'h0002);
    check("R13 restart served", 16'(rd_data), 16'hFA);
    check("R13 restart cfg", 16'(rd_cfg), 16'd1);

    // R9: other programmed pattern
    prog_lo = 8'hFF; prog_lock = 2'b00;
    wr_ctl(ARM); load(16'h0000);
    check("R9 all programmed", 16'(rd_data), 16'h00);
    wr_ctl(ARM); load(16'h0001);
    check("R10 lock unprogrammed", 16'(rd_data), 16'hFF);

    // R13: reset clears an open window
    wr_ctl(ARM);
    rst_n = 1'b0;
    idle(1);
    check("R13 reset clears", 16'(win_open), 16'd0);
    rst_n = 1'b1;
    idle(1);
    load(16'h0000);
    check("R13 after reset flash", 16'(rd_data), 16'(FLSH));

    finish_run();
  end

endmodule